// File: doc/BRIEF.md
# Scanned Key Matrix Emulator with Paced Event Queue

This block stands in for a passive keyboard matrix toward a host that scans it. The host drives strobe (column) lines and reads back sense (row) lines; the block answers combinationally, raising each sense line whose row holds a pressed key on an active strobe. Key activity arrives as 8-bit event codes. Each code is queued in a small FIFO and applied to the matrix at a slow, programmable pace, one event per tick. The pace keeps a scanning host from missing short press/release pairs.

A 128-entry translation table maps the low seven bits of an event code to a matrix position, written as row and column fields. The table starts with every entry unmapped and is loaded through an index/data write port before events are sent. Positions in row 7 are not matrix cells. They drive a few direct output lines, such as power or lid switches, and each of these lines passes through its own polarity invert. A restore input clears every held key and drops all queued events.

Top module: `keymatrix_emu`

## Requirements
- R1: After reset every sense line is low for any strobe pattern, `special_o` equals `invert_i`, `overflow_o` is low and every table entry is unmapped, so events sent before the table is loaded change nothing.
- R2: `sense_o[r]` is high exactly when some column c has `strobe_i[c]` high and cell (r,c) held. It follows strobe changes in the same cycle, with no clock edge.
- R3: A write with `tbl_we_i` high stores `tbl_data_i` at entry `tbl_idx_i`. An entry encodes the row in bits 6:4 and the column in bits 3:0, and an event selects its entry with its bits 6:0.
- R4: An event with bit 7 clear is a press and sets its mapped cell. An event with bit 7 set is a release and clears that cell.
- R5: An event has no effect when its entry is 8'hFF, when it names a row 0 to 6 with a column of 11 or more, or when it names row 7 with a column of 5 or more.
- R6: An entry in row 7 with column n from 0 to 4 controls special line n. `special_o[n]` equals the held state of that line XOR `invert_i[n]`, and it follows `invert_i` with no clock edge.
- R7: Up to 16 events are queued and applied in arrival order. An event offered while 16 are queued is dropped and sets `overflow_o`, which stays high until reset or restore.
- R8: A tick occurs every `tick_div_i`+1 cycles. At most one queued event is applied per tick, and it takes effect at the clock edge of that tick. Lowering `tick_div_i` below the running count makes a tick on the next edge.
- R9: A cycle with `restore_i` high clears every matrix cell, empties the queue and clears `overflow_o`. It takes priority over an event offered or applied in the same cycle. Special lines keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid_i | input | 1 | Offer one event code this cycle |
| ev_code_i | input | 8 | Event code: bit 7 release, bits 6:0 table index |
| restore_i | input | 1 | Clear matrix, queue and overflow flag |
| tick_div_i | input | 16 | Pacing divider; tick period is value+1 cycles |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 7 | Table entry to write |
| tbl_data_i | input | 8 | Table entry value (row 6:4, column 3:0, 8'hFF unmapped) |
| invert_i | input | 5 | Per-line polarity invert for special lines |
| strobe_i | input | 11 | Host strobe (column) lines, active high |
| sense_o | output | 7 | Sense (row) lines, active high |
| special_o | output | 5 | Direct special-key lines |
| overflow_o | output | 1 | Sticky queue overflow flag |

## Verification
The assertions assume that the translation table is written only while the event queue is empty. One of them checks this input rule, so a lookup never races a table update. The bench loads the whole table once, right after the queue has drained. It also waits a fixed number of ticks after each event, so the queue is always empty when the table changes. Where a check depends on exact pacing or a full queue, the bench first raises the divider to its maximum so that no tick can fall inside the fill window. It then lowers the divider to let the queue drain.

// File: rtl/keymatrix_pkg.sv
// Package: shared encodings for the key matrix emulator.
// Assumes the table entry layout is fixed: row field above column field.
package keymatrix_pkg;
    localparam int ROW_W    = 3;
    localparam int COL_W    = 4;
    localparam int ENTRY_W  = 8;
    localparam int SPEC_ROW = 7;

    typedef struct packed {
        logic             spare;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } entry_t;

    localparam entry_t UNMAPPED = entry_t'(8'hFF);
endpackage

// File: rtl/keymatrix_fifo.sv
// Module: event queue with sticky overflow.
// Holds DEPTH codes; a push while full is dropped and sets the flag.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module keymatrix_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic          empty_o,
    output logic [CW-1:0] count_o,
    output logic          ovf_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign full    = (count_o == CW'(DEPTH));
    assign empty_o = (count_o == '0);
    assign do_push = push_i && !full;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    // Purpose: store accepted codes in the slot the write pointer names.
    always_ff @(posedge clk) begin
        if (do_push && rst_n && !flush_i) begin
            mem[wr_ptr] <= data_i;
        end
    end

    // Purpose: advance pointers, keep the count and latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count_o <= count_o + CW'(do_push) - CW'(do_pop);
            if (push_i && full) ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/keymatrix_pacer.sv
// Module: tick generator; one tick every div_i+1 cycles.
// Assumes div_i may change at any time; a count at or above it ticks.
module keymatrix_pacer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = (cnt >= div_i);

    // Purpose: count cycles and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || tick_o) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/keymatrix_map.sv
// Module: translation table plus held-key state for matrix and special lines.
// Assumes the table is written only while no event is being applied.
module keymatrix_map
    import keymatrix_pkg::*;
#(
    parameter int N_ROWS    = 7,
    parameter int N_COLS    = 11,
    parameter int N_SPECIAL = 5,
    parameter int IDX_W     = 7,
    localparam int DEPTH    = 2 ** IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restore_i,
    input  logic                          tbl_we_i,
    input  logic [IDX_W-1:0]              tbl_idx_i,
    input  logic [ENTRY_W-1:0]            tbl_data_i,
    input  logic                          apply_i,
    input  logic [IDX_W:0]                code_i,
    output logic [N_ROWS-1:0][N_COLS-1:0] cells_o,
    output logic [N_SPECIAL-1:0]          spec_o
);
    entry_t tbl [DEPTH];
    entry_t ent;
    logic   press;
    logic   mapped;
    logic   hit_mtx;
    logic   hit_spec;

    assign ent      = tbl[code_i[IDX_W-1:0]];
    assign press    = !code_i[IDX_W];
    assign mapped   = (ent != UNMAPPED);
    assign hit_mtx  = mapped && (int'(ent.row) < N_ROWS) && (int'(ent.col) < N_COLS);
    assign hit_spec = mapped && (int'(ent.row) == SPEC_ROW) && (int'(ent.col) < N_SPECIAL);

    // Purpose: clear the table at reset, then accept index/data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= UNMAPPED;
        end else if (tbl_we_i) begin
            tbl[tbl_idx_i] <= entry_t'(tbl_data_i);
        end
    end

    // Purpose: set or clear the one matrix cell the applied event names.
    always_ff @(posedge clk) begin
        if (!rst_n || restore_i) begin
            cells_o <= '0;
        end else if (apply_i && hit_mtx) begin
            for (int r = 0; r < N_ROWS; r++) begin
                for (int c = 0; c < N_COLS; c++) begin
                    if (ent.row == ROW_W'(r) && ent.col == COL_W'(c)) cells_o[r][c] <= press;
                end
            end
        end
    end

    // Purpose: hold the press state of each special line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_o <= '0;
        end else if (apply_i && hit_spec && !restore_i) begin
            for (int n = 0; n < N_SPECIAL; n++) begin
                if (ent.col == COL_W'(n)) spec_o[n] <= press;
            end
        end
    end
endmodule

// File: rtl/keymatrix_emu.sv
// Module: top of the key matrix emulator.
// Queues event codes, applies one per tick, and answers host strobes
// combinationally on the sense lines. Assumes strobes are active high.
module keymatrix_emu
    import keymatrix_pkg::*;
#(
    parameter int N_ROWS     = 7,
    parameter int N_COLS     = 11,
    parameter int N_SPECIAL  = 5,
    parameter int IDX_W      = 7,
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16,
    localparam int CODE_W    = IDX_W + 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid_i,
    input  logic [CODE_W-1:0]    ev_code_i,
    input  logic                 restore_i,
    input  logic [DIV_W-1:0]     tick_div_i,
    input  logic                 tbl_we_i,
    input  logic [IDX_W-1:0]     tbl_idx_i,
    input  logic [ENTRY_W-1:0]   tbl_data_i,
    input  logic [N_SPECIAL-1:0] invert_i,
    input  logic [N_COLS-1:0]    strobe_i,
    output logic [N_ROWS-1:0]    sense_o,
    output logic [N_SPECIAL-1:0] special_o,
    output logic                 overflow_o
);
    logic                          tick_w;
    logic                          fifo_empty_w;
    logic [CODE_W-1:0]             head_w;
    logic [CNT_W-1:0]              fifo_cnt_w;
    logic                          apply_w;
    logic [N_ROWS-1:0][N_COLS-1:0] cells_w;
    logic [N_SPECIAL-1:0]          spec_w;

    assign apply_w = tick_w && !fifo_empty_w;

    keymatrix_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (tick_div_i),
        .tick_o (tick_w)
    );

    keymatrix_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (restore_i),
        .push_i  (ev_valid_i),
        .data_i  (ev_code_i),
        .pop_i   (tick_w),
        .head_o  (head_w),
        .empty_o (fifo_empty_w),
        .count_o (fifo_cnt_w),
        .ovf_o   (overflow_o)
    );

    keymatrix_map #(
        .N_ROWS(N_ROWS), .N_COLS(N_COLS), .N_SPECIAL(N_SPECIAL), .IDX_W(IDX_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .restore_i  (restore_i),
        .tbl_we_i   (tbl_we_i),
        .tbl_idx_i  (tbl_idx_i),
        .tbl_data_i (tbl_data_i),
        .apply_i    (apply_w),
        .code_i     (head_w),
        .cells_o    (cells_w),
        .spec_o     (spec_w)
    );

    // Purpose: one sense line per row, high when a held key meets a strobe.
    for (genvar r = 0; r < N_ROWS; r++) begin : g_sense
        assign sense_o[r] = |(cells_w[r] & strobe_i);
    end

    // Purpose: special lines carry held state through the polarity mask.
    assign special_o = spec_w ^ invert_i;
endmodule

// File: rtl/keymatrix_checker.sv
// Module: property checker bound to keymatrix_emu.
// Assumes table writes occur only with an empty queue (checked below).
module keymatrix_checker #(
    parameter int N_ROWS     = 7,
    parameter int N_COLS     = 11,
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restore_i,
    input logic              ev_valid_i,
    input logic              tbl_we_i,
    input logic [N_COLS-1:0] strobe_i,
    input logic [N_ROWS-1:0] sense_o,
    input logic              overflow_o,
    input logic              tick,
    input logic [CNT_W-1:0]  fifo_cnt
);
    a_r2_no_strobe_no_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i == '0) |-> (sense_o == '0));

    a_r9_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (fifo_cnt == '0 && !overflow_o && sense_o == '0));

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !restore_i) |=> overflow_o);

    a_r7_full_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && int'(fifo_cnt) == FIFO_DEPTH && !restore_i) |=> overflow_o);

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= FIFO_DEPTH);

    a_r8_one_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !restore_i |=> (int'(fifo_cnt) + 1 >= int'($past(fifo_cnt))));

    a_r8_no_pop_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restore_i) |=> (fifo_cnt >= $past(fifo_cnt)));

    a_r3_table_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we_i |-> (fifo_cnt == '0));
endmodule

bind keymatrix_emu keymatrix_checker #(
    .N_ROWS(N_ROWS), .N_COLS(N_COLS), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restore_i  (restore_i),
    .ev_valid_i (ev_valid_i),
    .tbl_we_i   (tbl_we_i),
    .strobe_i   (strobe_i),
    .sense_o    (sense_o),
    .overflow_o (overflow_o),
    .tick       (tick_w),
    .fifo_cnt   (fifo_cnt_w)
);

// File: tb/test_keymatrix_emu.sv
// Bench: directed scenarios, one task each, for keymatrix_emu.
module test_keymatrix_emu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic        restore = 1'b0;
    logic [15:0] tick_div = 16'd3;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_idx = '0;
    logic [7:0]  tbl_data = '0;
    logic [4:0]  invert = 5'b10100;
    logic [10:0] strobe = '1;
    logic [6:0]  sense;
    logic [4:0]  special;
    logic        overflow;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    keymatrix_emu i_keymatrix_emu (
        .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid), .ev_code_i(ev_code),
        .restore_i(restore), .tick_div_i(tick_div), .tbl_we_i(tbl_we),
        .tbl_idx_i(tbl_idx), .tbl_data_i(tbl_data), .invert_i(invert),
        .strobe_i(strobe), .sense_o(sense), .special_o(special),
        .overflow_o(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] code);
        ev_code = code;
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr_tbl(input logic [6:0] idx, input logic [7:0] val);
        tbl_idx = idx;
        tbl_data = val;
        tbl_we = 1'b1;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1 sense after reset", 32'(sense), 32'h0);
        chk("R1 special equals invert", 32'(special), 32'(invert));
        chk("R1 overflow low", 32'(overflow), 32'h0);
        send(8'h10);
        cycles(20);
        chk("R1 unmapped table ignores event", 32'(sense), 32'h0);
    endtask

    task automatic t_load_table;
        wr_tbl(7'h10, 8'h00);
        wr_tbl(7'h11, 8'h25);
        wr_tbl(7'h12, 8'h6A);
        wr_tbl(7'h13, 8'h71);
        wr_tbl(7'h14, 8'h3C);
        wr_tbl(7'h15, 8'h76);
        wr_tbl(7'h17, 8'h43);
    endtask

    task automatic t_sense;
        send(8'h10);
        send(8'h11);
        cycles(20);
        strobe = '0;
        #1 chk("R2 no strobe", 32'(sense), 32'h0);
        strobe = 11'h001;
        #1 chk("R2 R3 col0 row0", 32'(sense), 32'h01);
        strobe = 11'h020;
        #1 chk("R2 R3 col5 row2", 32'(sense), 32'h04);
        strobe = 11'h021;
        #1 chk("R2 both strobes", 32'(sense), 32'h05);
        strobe = 11'h7DE;
        #1 chk("R2 unrelated strobes", 32'(sense), 32'h0);
        strobe = '1;
        send(8'h90);
        cycles(20);
        chk("R4 release row0 only", 32'(sense), 32'h04);
        send(8'h91);
        cycles(20);
        chk("R4 release all", 32'(sense), 32'h0);
    endtask

    task automatic t_ignore;
        send(8'h14);
        send(8'h15);
        send(8'h16);
        cycles(30);
        chk("R5 ignored sense", 32'(sense), 32'h0);
        chk("R5 ignored special", 32'(special), 32'(invert));
    endtask

    task automatic t_special;
        invert = 5'b00000;
        send(8'h13);
        cycles(20);
        chk("R6 special press", 32'(special), 32'h02);
        chk("R6 matrix untouched", 32'(sense), 32'h0);
        invert = 5'b00011;
        #1 chk("R6 invert follows", 32'(special), 32'h01);
        send(8'h93);
        cycles(20);
        chk("R6 special release", 32'(special), 32'h03);
    endtask

    task automatic t_pacing;
        int k;
        tick_div = 16'd49;
        send(8'h10);
        send(8'h12);
        k = 0;
        while (!sense[0] && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk("R8 first event applied", 32'(sense[0]), 32'h1);
        chk("R8 second not same tick", 32'(sense[6]), 32'h0);
        cycles(25);
        chk("R8 second waits a period", 32'(sense[6]), 32'h0);
        cycles(30);
        chk("R8 second after next tick", 32'(sense[6]), 32'h1);
        tick_div = 16'd3;
        send(8'h90);
        send(8'h92);
        cycles(20);
        chk("R8 released", 32'(sense), 32'h0);
    endtask

    task automatic t_fifo;
        tick_div = 16'hFFFF;
        cycles(2);
        for (int i = 0; i < 7; i++) begin
            send(8'h10);
            send(8'h90);
        end
        send(8'h17);
        send(8'h90);
        chk("R7 no overflow at 16", 32'(overflow), 32'h0);
        send(8'h12);
        chk("R7 overflow on 17th", 32'(overflow), 32'h1);
        tick_div = 16'd3;
        cycles(100);
        chk("R7 order kept, 17th dropped", 32'(sense), 32'h10);
        chk("R7 overflow sticky", 32'(overflow), 32'h1);
    endtask

    task automatic t_restore;
        tick_div = 16'hFFFF;
        cycles(2);
        send(8'h10);
        restore = 1'b1;
        @(negedge clk);
        restore = 1'b0;
        chk("R9 cells cleared", 32'(sense), 32'h0);
        chk("R9 overflow cleared", 32'(overflow), 32'h0);
        chk("R9 special kept", 32'(special), 32'(invert));
        tick_div = 16'd3;
        cycles(30);
        chk("R9 queue emptied", 32'(sense), 32'h0);
        send(8'h10);
        cycles(20);
        chk("R9 works after restore", 32'(sense), 32'h01);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_load_table();
        t_sense();
        t_ignore();
        t_special();
        t_pacing();
        t_fifo();
        t_restore();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule